// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Front End

This block is the control side of a synchronous, common-I/O memory with a 16-bit data word plus two parity bits, built around an internal array. On each rising clock edge it samples three chip enables and two address strobes: one intended for a host processor and one for a memory controller. When an access starts, it loads the address register and a 2-bit burst counter. It then carries out single reads or single writes, either whole-word or per-byte.

The two strobes differ in priority and in when they look at the write inputs. The host strobe always opens a read-looking first cycle and leaves any write to the following edge. The controller strobe writes in the same edge that loads the address. The shared data bus is modelled as separate in and out buses plus a drive flag. That flag goes low as soon as write inputs are shown, whatever the output enable says.

A burst-advance input steps the low two address bits through one of two wrap-around orders: linear or XOR-interleaved. A mode input picks the order.

Top module: `sbs_burst_front`

## Requirements
- R1: An access starts at a rising edge only when ce_a_n is low, ce_b is high, ce_c_n is low and at least one strobe (hstrb_n or cstrb_n) is low. burst_addr then equals addr after that edge. With any enable inactive, nothing is loaded.
- R2: When hstrb_n starts an access, the write inputs at that edge are ignored and the edge behaves as a read. If the write inputs show a write at the next edge, dat_i/par_i are written to the loaded address at that edge.
- R3: cstrb_n starts an access only while hstrb_n is high. If the write inputs show a write at that same edge, the data is written at once to addr. When both strobes are low, the access follows the host rule of R2 and nothing is written on that edge.
- R4: Write decode: wr_all_n low writes both lanes whatever lane_n shows. Otherwise, with wr_byte_n low, each lane i whose lane_n[i] is low is written. Every other combination is a read.
- R5: Lane 0 is dat[7:0] together with par[0]. Lane 1 is dat[15:8] together with par[1]. An unselected lane keeps its stored contents.
- R6: bus_drive is high only while oe_n is low, the last edge was a read cycle of an active access, and the write inputs currently show no write. It drops the moment a write (including a byte write) is shown, even with oe_n low.
- R7: After a read edge, dat_o and par_o hold the stored word at the burst_addr that edge loaded.
- R8: While an access is active and no new one starts, step_n low at an edge advances the burst. With start offset s and step index k, order_il=0 gives low bits (s+k) mod 4 and order_il=1 gives s XOR k. The upper address bits are kept, and the sequence wraps after four steps.
- R9: With step_n high and no start, burst_addr holds. After reset, burst_addr is 0, bus_drive is 0 and no access is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_a_n | input | 1 | Chip enable A, active low; also gates the host strobe |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| hstrb_n | input | 1 | Host address strobe, active low, higher priority |
| cstrb_n | input | 1 | Controller address strobe, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 2 | Per-lane byte selects, active low |
| step_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 8 | Word address |
| dat_i | input | 16 | Write data |
| par_i | input | 2 | Write parity |
| dat_o | output | 16 | Read data |
| par_o | output | 2 | Read parity |
| bus_drive | output | 1 | Data and parity bus drive enable |
| burst_addr | output | 8 | Current array address |

## Verification
Address loading, burst steps and read data are all due one edge after the stimulus. The bench therefore drives inputs on the falling edge, waits through exactly one rising edge and compares on the next falling edge. A write is never observed directly. It is proven by a controller read issued later, whose data is compared one edge after that read's start.

bus_drive has no register between write inputs or oe_n and the output, so it is checked a few nanoseconds after those inputs change, with no clock edge in between. Burst checks run for all four start offsets in both orders, including the wrap step.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int OFF_W = 2;
  typedef logic [OFF_W-1:0] off_t;

  // offset of the k-th beat of a burst that began at st
  function automatic off_t seq_off(off_t st, off_t k, logic il);
    return il ? (st ^ k) : off_t'(st + k);
  endfunction
endpackage

// File: rtl/sbs_access_decode.sv
module sbs_access_decode #(
  parameter int LANES = 2
) (
  input  logic             ce_a_n,
  input  logic             ce_b,
  input  logic             ce_c_n,
  input  logic             hstrb_n,
  input  logic             cstrb_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  output logic             host_go,
  output logic             ctl_go,
  output logic             wr_req,
  output logic [LANES-1:0] lane_we
);
  logic sel;

  always_comb begin
    sel     = !ce_a_n && ce_b && !ce_c_n;
    host_go = sel && !hstrb_n;
    ctl_go  = sel && hstrb_n && !cstrb_n;
    if (!wr_all_n)       lane_we = '1;
    else if (!wr_byte_n) lane_we = ~lane_n;
    else                 lane_we = '0;
    wr_req = |lane_we;
  end
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  input  logic il,
  input  off_t ld_off,
  output off_t off_q,
  output off_t nxt_off
);
  off_t st_q, k_q, k_nxt;

  always_comb begin
    k_nxt = k_q;
    if (load)      k_nxt = '0;
    else if (step) k_nxt = off_t'(k_q + 1'b1);
    nxt_off = load ? ld_off : seq_off(st_q, k_nxt, il);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      k_q   <= '0;
      off_q <= '0;
    end else begin
      if (load) st_q <= ld_off;
      k_q   <= k_nxt;
      off_q <= nxt_off;
    end
  end
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int AW    = 8,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*LW-1:0] wdat,
  input  logic [LANES-1:0]    wpar,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdat,
  output logic [LANES-1:0]    rpar
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW:0] mem [DEPTH];
    logic [LW:0] rd_q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= {wpar[g], wdat[g*LW +: LW]};
      rd_q <= mem[raddr];
    end
    assign rdat[g*LW +: LW] = rd_q[LW-1:0];
    assign rpar[g]          = rd_q[LW];
  end
endmodule

// File: rtl/sbs_burst_front.sv
module sbs_burst_front
  import sbs_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_a_n,
  input  logic                ce_b,
  input  logic                ce_c_n,
  input  logic                hstrb_n,
  input  logic                cstrb_n,
  input  logic                wr_all_n,
  input  logic                wr_byte_n,
  input  logic [LANES-1:0]    lane_n,
  input  logic                step_n,
  input  logic                order_il,
  input  logic                oe_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] dat_i,
  input  logic [LANES-1:0]    par_i,
  output logic [LANES*LW-1:0] dat_o,
  output logic [LANES-1:0]    par_o,
  output logic                bus_drive,
  output logic [AW-1:0]       burst_addr
);
  localparam int HW = AW - OFF_W;

  logic             host_go, ctl_go, wr_req, go, cont, step;
  logic [LANES-1:0] lane_we, we_eff;
  logic             active_q, drv_q;
  logic [HW-1:0]    hi_q, hi_nxt;
  off_t             off_q, nxt_off;
  logic [AW-1:0]    waddr, raddr;

  sbs_access_decode #(.LANES(LANES)) u_dec (
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .hstrb_n(hstrb_n), .cstrb_n(cstrb_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
    .host_go(host_go), .ctl_go(ctl_go), .wr_req(wr_req), .lane_we(lane_we)
  );

  always_comb begin
    go     = host_go || ctl_go;
    cont   = active_q && !go;
    step   = cont && !step_n;
    // host start never writes; controller start and continuing cycles may
    we_eff = ((ctl_go || cont) && wr_req) ? lane_we : '0;
    waddr  = ctl_go ? addr : {hi_q, off_q};
    hi_nxt = go ? addr[AW-1:OFF_W] : hi_q;
    raddr  = {hi_nxt, nxt_off};
  end

  sbs_burst_ctr u_ctr (
    .clk(clk), .rst(rst), .load(go), .step(step), .il(order_il),
    .ld_off(addr[OFF_W-1:0]), .off_q(off_q), .nxt_off(nxt_off)
  );

  sbs_lane_ram #(.AW(AW), .LANES(LANES), .LW(LW)) u_ram (
    .clk(clk), .we(we_eff), .waddr(waddr), .wdat(dat_i), .wpar(par_i),
    .raddr(raddr), .rdat(dat_o), .rpar(par_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      drv_q    <= 1'b0;
    end else begin
      if (go) active_q <= 1'b1;
      hi_q <= hi_nxt;
      if (host_go)          drv_q <= 1'b1;
      else if (ctl_go||cont) drv_q <= !wr_req;
      else                  drv_q <= 1'b0;
    end
  end

  assign bus_drive  = drv_q && !oe_n && !wr_req;
  assign burst_addr = {hi_q, off_q};
endmodule

// File: rtl/sbs_front_chk.sv
module sbs_front_chk #(
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_a_n,
  input logic             ce_b,
  input logic             ce_c_n,
  input logic             hstrb_n,
  input logic             cstrb_n,
  input logic             wr_all_n,
  input logic             wr_byte_n,
  input logic [LANES-1:0] lane_n,
  input logic             step_n,
  input logic             order_il,
  input logic             oe_n,
  input logic [AW-1:0]    addr,
  input logic             bus_drive,
  input logic [AW-1:0]    burst_addr,
  input logic             active
);
  logic sel_c, go_c, wr_shown;
  assign sel_c    = !ce_a_n && ce_b && !ce_c_n;
  assign go_c     = sel_c && (!hstrb_n || !cstrb_n);
  assign wr_shown = !wr_all_n || (!wr_byte_n && (lane_n != '1));

  a_r1_load_addr: assert property (@(posedge clk) disable iff (rst)
    (!rst && go_c) |=> (burst_addr == $past(addr)));

  a_r2_first_cycle_read: assert property (@(posedge clk) disable iff (rst)
    (!rst && sel_c && !hstrb_n) |=> (oe_n || wr_shown || bus_drive));

  a_r6_write_tristate: assert property (@(posedge clk) disable iff (rst)
    wr_shown |-> !bus_drive);

  a_r6_oe_gate: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !bus_drive);

  a_r8_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!rst && active && !go_c && !step_n && !order_il) |=>
      ((burst_addr[1:0] == 2'($past(burst_addr[1:0]) + 2'd1)) &&
       (burst_addr[AW-1:2] == $past(burst_addr[AW-1:2]))));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !go_c && step_n) |=> $stable(burst_addr));
endmodule

bind sbs_burst_front sbs_front_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
  .hstrb_n(hstrb_n), .cstrb_n(cstrb_n), .wr_all_n(wr_all_n),
  .wr_byte_n(wr_byte_n), .lane_n(lane_n), .step_n(step_n),
  .order_il(order_il), .oe_n(oe_n), .addr(addr), .bus_drive(bus_drive),
  .burst_addr(burst_addr), .active(active_q)
);

// File: tb/test_sbs_burst_front.sv
module test_sbs_burst_front;
  logic clk = 0, rst = 1;
  logic ce_a_n = 1, ce_b = 0, ce_c_n = 1, hstrb_n = 1, cstrb_n = 1;
  logic wr_all_n = 1, wr_byte_n = 1, step_n = 1, order_il = 0, oe_n = 0;
  logic [1:0] lane_n = 2'b11;
  logic [7:0] addr = 0;
  logic [15:0] dat_i = 0;
  logic [1:0] par_i = 0;
  logic [15:0] dat_o;
  logic [1:0] par_o;
  logic bus_drive;
  logic [7:0] burst_addr;

  logic [17:0] mm [256];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sbs_burst_front i_sbs_burst_front (
    .clk(clk), .rst(rst), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .hstrb_n(hstrb_n), .cstrb_n(cstrb_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .lane_n(lane_n), .step_n(step_n),
    .order_il(order_il), .oe_n(oe_n), .addr(addr), .dat_i(dat_i),
    .par_i(par_i), .dat_o(dat_o), .par_o(par_o), .bus_drive(bus_drive),
    .burst_addr(burst_addr)
  );

  function automatic [17:0] merge(input [17:0] old, input [15:0] d, input [1:0] p,
                                  input an, input bn, input [1:0] ln);
    logic [1:0] we;
    logic [17:0] r;
    we = !an ? 2'b11 : (!bn ? ~ln : 2'b00);
    r = old;
    for (int i = 0; i < 2; i++)
      if (we[i]) begin
        r[i*8 +: 8] = d[i*8 +: 8];
        r[16+i]     = p[i];
      end
    return r;
  endfunction

  function automatic [1:0] exp_off(input [1:0] s, input [1:0] k, input il);
    return il ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    hstrb_n = 1; cstrb_n = 1; wr_all_n = 1; wr_byte_n = 1; lane_n = 2'b11; step_n = 1;
  endtask

  task automatic select(input bit on);
    ce_a_n = !on; ce_b = on; ce_c_n = !on;
  endtask

  task automatic ctl_write(input [7:0] a, input [15:0] d, input [1:0] p,
                           input an, input bn, input [1:0] ln);
    select(1); hstrb_n = 1; cstrb_n = 0; addr = a; dat_i = d; par_i = p;
    wr_all_n = an; wr_byte_n = bn; lane_n = ln;
    tick;
    mm[a] = merge(mm[a], d, p, an, bn, ln);
    idle;
  endtask

  task automatic ctl_read(input [7:0] a, input string req);
    select(1); hstrb_n = 1; cstrb_n = 0; addr = a;
    tick;
    idle;
    #1;
    chk({par_o, dat_o} == mm[a], req, {par_o, dat_o}, mm[a]);
    chk(bus_drive == 1'b1, req, bus_drive, 1);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] a0, pa;
    seed = $urandom(32'd91);
    repeat (3) tick;
    rst = 0;
    #1;
    // R9: reset state
    chk(bus_drive == 0, "R9 reset drive", bus_drive, 0);
    chk(burst_addr == 0, "R9 reset addr", burst_addr, 0);

    // fill memory with whole-word controller writes (R3, R4)
    for (int a = 0; a < 256; a++) begin
      mm[a] = 18'h0;
      ctl_write(8'(a), 16'($urandom), 2'($urandom), 0, 1, 2'b11);
    end
    for (int a = 0; a < 8; a++) ctl_read(8'(a * 31), "R3 R7 fill readback");

    // R1: no start without all enables
    ctl_read(8'h10, "R7 setup");
    pa = burst_addr;
    ce_b = 0; ce_a_n = 0; ce_c_n = 0; hstrb_n = 0; cstrb_n = 0; addr = 8'hA5;
    tick; idle; #1;
    chk(burst_addr == pa, "R1 ce_b low ignored", burst_addr, pa);
    ce_a_n = 1; ce_b = 1; ce_c_n = 0; hstrb_n = 0; addr = 8'h5A;
    tick; idle; #1;
    chk(burst_addr == pa, "R1 ce_a_n high host ignored", burst_addr, pa);

    // R2: host start ignores write inputs, writes at next edge with lane 0 only (R5)
    a0 = 8'h42;
    select(1); hstrb_n = 0; addr = a0; wr_all_n = 0; dat_i = 16'hDEAD; par_i = 2'b11;
    tick;
    hstrb_n = 1; wr_all_n = 1; wr_byte_n = 0; lane_n = 2'b10; dat_i = 16'h1234; par_i = 2'b01;
    #1;
    chk(bus_drive == 0, "R6 byte write tristates", bus_drive, 0);
    chk(burst_addr == a0, "R2 host load", burst_addr, a0);
    tick;
    mm[a0] = merge(mm[a0], 16'h1234, 2'b01, 1, 0, 2'b10);
    idle;
    ctl_read(a0, "R2 R5 host lane0 write");
    ctl_write(a0, 16'hABCD, 2'b10, 1, 0, 2'b01);
    ctl_read(a0, "R4 R5 ctl lane1 write");
    ctl_write(a0, 16'h5555, 2'b00, 0, 0, 2'b11);
    ctl_read(a0, "R4 global write overrides lanes");
    ctl_write(a0, 16'h9999, 2'b11, 1, 0, 2'b11);
    ctl_read(a0, "R4 no lanes selected is read");

    // R3: both strobes low with write shown -> host path, no write
    select(1); hstrb_n = 0; cstrb_n = 0; addr = a0; wr_all_n = 0; dat_i = 16'h0BAD;
    tick; idle; #1;
    chk(bus_drive == 1, "R3 both strobes read cycle", bus_drive, 1);
    chk({par_o, dat_o} == mm[a0], "R3 both strobes no write", {par_o, dat_o}, mm[a0]);
    // R6: asynchronous gating
    wr_all_n = 0; #1;
    chk(bus_drive == 0, "R6 write shown tristates", bus_drive, 0);
    wr_all_n = 1; oe_n = 1; #1;
    chk(bus_drive == 0, "R6 oe high", bus_drive, 0);
    oe_n = 0; #1;
    chk(bus_drive == 1, "R6 drive restored", bus_drive, 1);
    ctl_read(a0, "R3 both strobes memory unchanged");

    // R8: every start offset, both orders, including wrap
    for (int il = 0; il < 2; il++)
      for (int s = 0; s < 4; s++) begin
        logic [7:0] b;
        order_il = il[0];
        b = {6'($urandom), 2'(s)};
        select(1); hstrb_n = 0; addr = b; tick; idle; #1;
        chk(burst_addr == b, "R8 burst start", burst_addr, b);
        for (int k = 1; k <= 4; k++) begin
          logic [7:0] e;
          e = {b[7:2], exp_off(2'(s), 2'(k), il[0])};
          step_n = 0; tick; step_n = 1; #1;
          chk(burst_addr == e, "R8 burst order", burst_addr, e);
          chk({par_o, dat_o} == mm[e], "R7 R8 burst data", {par_o, dat_o}, mm[e]);
        end
        tick; #1;
        chk(burst_addr == {b[7:2], exp_off(2'(s), 2'd0, il[0])}, "R9 hold", burst_addr, b);
      end

    // random mix of controller writes and reads
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ra;
      ra = 8'($urandom);
      if ($urandom % 2)
        ctl_write(ra, 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
      else
        ctl_read(ra, "R4 R7 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule